// File: doc/BRIEF.md
# Single-Accumulator 8-bit Execution Core

This block executes a stream of 8-bit instructions on one 8-bit working value and a separate sign flag. Each instruction comes from a read-only instruction bank. A bank-pointer register selects the bank, and the program counter gives the address inside it. Every instruction finishes in one clock unless it waits for an operand from a neighbouring core. Branching switches the core to a different bank and restarts the program counter at zero. No branch targets an address inside a bank.

Instruction memory sits on a plain combinational read port. The core drives the bank and address, and the instruction word must be present on `instr_data` in the same cycle. Neighbour operands arrive on a valid/ready port. The core raises `opnd_ready` only while the current instruction needs a neighbour value and the core has not halted. An operand transfers on a rising clock edge where `opnd_ready` and `opnd_valid` are both high. While `opnd_ready` is high and `opnd_valid` is low, the core stalls and holds every register. The producer may hold `opnd_valid` high at any time, and the core ignores it unless `opnd_ready` is high. A halt instruction stops the core for good until the next reset, and the working value is then shown on `halt_val`.

Top module: `acc_core`

## Requirements
- R1: When `rst_n` is low at a clock edge, the core sets the working value to 0, the sign flag to 0, the PC to 0, the bank pointer to the BOOT_BANK parameter, the multiplexer direction to 13 (centre) and halted to 0.
- R2: The instruction address is the PC and the instruction bank is the bank pointer. Every instruction that does not stall, branch or halt adds 1 to the PC, and the PC wraps from 255 to 0.
- R3: Opcode 0x1 (load-low) writes the argument in bits 3:0 into value bits 3:0 and keeps bits 7:4. Opcode 0x2 (load-high) writes the argument into value bits 7:4 and keeps bits 3:0.
- R4: Opcode 0x3 shifts the value left and opcode 0x4 shifts it right, by the argument amount (0 to 15). Vacated bits fill with zero, and the sign flag does not change.
- R5: Opcode 0x7 ANDs value bits 3:0 with the argument and clears bits 7:4. Opcode 0x8 ORs the argument into bits 3:0 and keeps bits 7:4.
- R6: Opcode 0x5 adds the zero-extended argument to the value and opcode 0x6 subtracts it, both modulo 256. The sign flag becomes bit 7 of the result.
- R7: Opcode 0x0 with argument 2, 3, 4 or 5 needs a neighbour operand. Argument 2 loads it into the value and keeps the sign. Argument 3 adds it and argument 4 subtracts it, both setting the sign from bit 7 of the result. Argument 5 discards it. `opnd_ready` is high exactly while such an instruction is current and the core is not halted. Without `opnd_valid`, no register changes.
- R8: Opcodes 0x9 (always), 0xA (value < 0), 0xB (value = 0) and 0xC (value > 0) compare the value as signed. When the condition holds, the core loads the argument into the bank pointer and clears the PC. When it fails, the PC steps by 1.
- R9: An instruction with bits 7:5 = 111 loads bits 4:0 into the 5-bit multiplexer direction output. No other instruction changes it.
- R10: Opcode 0x0 with argument 1 sets `halted`, and after that no register changes. `halt_val` shows the value while halted and 0 otherwise, and `opnd_ready` stays low while halted. Opcode 0x0 with argument 0 or 6 to 15, and opcode 0xD, are no-operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_bank | output | BANK_W | Bank pointer driving the instruction read |
| instr_addr | output | PC_W | Program counter driving the instruction read |
| instr_data | input | 8 | Instruction word for the current bank and address |
| opnd_ready | output | 1 | Core is waiting for a neighbour operand |
| opnd_valid | input | 1 | Neighbour operand present |
| opnd_data | input | 8 | Neighbour operand value |
| mux_dir | output | 5 | Multiplexer direction register |
| acc_val | output | 8 | Working value |
| sign_flag | output | 1 | Sign flag |
| halted | output | 1 | Core has executed halt |
| halt_val | output | 8 | Working value while halted, else 0 |

## Verification
The bench targets the shift-right case where 0xBF becomes 0x5F. A core that used an arithmetic shift would return 0xDF instead, and one whose shift touched the sign flag would clear it in the middle of a negative sequence. The bench also drives the nibble AND and OR in turn, so a core that swapped their upper-half rules would leave stale high bits after AND or would wipe them after OR. It holds a neighbour load stalled for a cycle and checks that the PC, value and direction do not move, and a core that advanced anyway would skip an instruction. It runs jumps taken and not taken on zero, negative and positive values, steps the PC through its wrap from 255 to 0, and checks that instructions given after a halt change nothing.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int WORD_W = 8;
  localparam int ARG_W  = 4;
  localparam int DIR_W  = 5;
  localparam logic [DIR_W-1:0] DIR_CENTRE = 5'd13;

  typedef enum logic [3:0] {
    K_NOP, K_HALT, K_LDLO, K_LDHI, K_SHL, K_SHR, K_ADDK, K_SUBK,
    K_ANDK, K_ORK, K_NLD, K_NADD, K_NSUB, K_NDROP, K_JUMP, K_SETMUX
  } kind_e;

  typedef enum logic [1:0] {C_ALWAYS, C_LT, C_EQ, C_GT} cond_e;

  typedef struct packed {
    kind_e             kind;
    cond_e             cond;
    logic [ARG_W-1:0]  arg;
    logic [DIR_W-1:0]  dir;
    logic              needs_opnd;
  } dec_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_core_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output dec_t              dec
);
  logic [3:0] opc;
  assign opc = instr[7:4];

  always_comb begin
    dec.kind       = K_NOP;
    dec.cond       = C_ALWAYS;
    dec.arg        = instr[ARG_W-1:0];
    dec.dir        = instr[DIR_W-1:0];
    dec.needs_opnd = 1'b0;
    if (instr[7:5] == 3'b111) begin
      dec.kind = K_SETMUX;
    end else begin
      unique case (opc)
        4'h0: begin
          unique case (instr[3:0])
            4'h1:    dec.kind = K_HALT;
            4'h2:    begin dec.kind = K_NLD;   dec.needs_opnd = 1'b1; end
            4'h3:    begin dec.kind = K_NADD;  dec.needs_opnd = 1'b1; end
            4'h4:    begin dec.kind = K_NSUB;  dec.needs_opnd = 1'b1; end
            4'h5:    begin dec.kind = K_NDROP; dec.needs_opnd = 1'b1; end
            default: dec.kind = K_NOP;
          endcase
        end
        4'h1: dec.kind = K_LDLO;
        4'h2: dec.kind = K_LDHI;
        4'h3: dec.kind = K_SHL;
        4'h4: dec.kind = K_SHR;
        4'h5: dec.kind = K_ADDK;
        4'h6: dec.kind = K_SUBK;
        4'h7: dec.kind = K_ANDK;
        4'h8: dec.kind = K_ORK;
        4'h9: begin dec.kind = K_JUMP; dec.cond = C_ALWAYS; end
        4'hA: begin dec.kind = K_JUMP; dec.cond = C_LT;     end
        4'hB: begin dec.kind = K_JUMP; dec.cond = C_EQ;     end
        4'hC: begin dec.kind = K_JUMP; dec.cond = C_GT;     end
        default: dec.kind = K_NOP;
      endcase
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_core_pkg::*;
(
  input  kind_e             kind,
  input  logic [ARG_W-1:0]  arg,
  input  logic [WORD_W-1:0] val,
  input  logic              sign,
  input  logic [WORD_W-1:0] opnd,
  output logic [WORD_W-1:0] val_nx,
  output logic              sign_nx
);
  logic [WORD_W-1:0] argx;
  assign argx = {{(WORD_W-ARG_W){1'b0}}, arg};

  always_comb begin
    val_nx  = val;
    sign_nx = sign;
    unique case (kind)
      K_LDLO: val_nx = {val[WORD_W-1:ARG_W], arg};
      K_LDHI: val_nx = {arg, val[ARG_W-1:0]};
      K_SHL:  val_nx = val << arg;
      K_SHR:  val_nx = val >> arg;
      K_ADDK: begin val_nx = val + argx; sign_nx = val_nx[WORD_W-1]; end
      K_SUBK: begin val_nx = val - argx; sign_nx = val_nx[WORD_W-1]; end
      K_ANDK: val_nx = {{(WORD_W-ARG_W){1'b0}}, val[ARG_W-1:0] & arg};
      K_ORK:  val_nx = {val[WORD_W-1:ARG_W], val[ARG_W-1:0] | arg};
      K_NLD:  val_nx = opnd;
      K_NADD: begin val_nx = val + opnd; sign_nx = val_nx[WORD_W-1]; end
      K_NSUB: begin val_nx = val - opnd; sign_nx = val_nx[WORD_W-1]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_branch.sv
module acc_branch
  import acc_core_pkg::*;
(
  input  logic              is_jump,
  input  cond_e             cond,
  input  logic [WORD_W-1:0] val,
  output logic              taken
);
  logic neg, zero;
  assign neg  = val[WORD_W-1];
  assign zero = (val == '0);

  always_comb begin
    unique case (cond)
      C_ALWAYS: taken = is_jump;
      C_LT:     taken = is_jump & neg;
      C_EQ:     taken = is_jump & zero;
      C_GT:     taken = is_jump & ~neg & ~zero;
      default:  taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int PC_W      = 8,
  parameter int BANK_W    = 8,
  parameter int BOOT_BANK = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [BANK_W-1:0] instr_bank,
  output logic [PC_W-1:0]   instr_addr,
  input  logic [WORD_W-1:0] instr_data,
  output logic              opnd_ready,
  input  logic              opnd_valid,
  input  logic [WORD_W-1:0] opnd_data,
  output logic [DIR_W-1:0]  mux_dir,
  output logic [WORD_W-1:0] acc_val,
  output logic              sign_flag,
  output logic              halted,
  output logic [WORD_W-1:0] halt_val
);
  localparam logic [BANK_W-1:0] BOOT = BANK_W'(BOOT_BANK);

  logic [PC_W-1:0]   pc_q;
  logic [BANK_W-1:0] bank_q;
  logic [WORD_W-1:0] val_q, val_nx;
  logic              sign_q, sign_nx;
  logic [DIR_W-1:0]  dir_q;
  logic              halt_q;
  dec_t              dec;
  logic              taken, stall, run;

  acc_decode u_dec (.instr(instr_data), .dec(dec));

  acc_alu u_alu (
    .kind(dec.kind), .arg(dec.arg), .val(val_q), .sign(sign_q),
    .opnd(opnd_data), .val_nx(val_nx), .sign_nx(sign_nx)
  );

  acc_branch u_br (
    .is_jump(dec.kind == K_JUMP), .cond(dec.cond), .val(val_q), .taken(taken)
  );

  assign opnd_ready = dec.needs_opnd & ~halt_q;
  assign stall      = opnd_ready & ~opnd_valid;
  assign run        = ~halt_q & ~stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      bank_q <= BOOT;
      val_q  <= '0;
      sign_q <= 1'b0;
      dir_q  <= DIR_CENTRE;
      halt_q <= 1'b0;
    end else if (run) begin
      val_q  <= val_nx;
      sign_q <= sign_nx;
      if (dec.kind == K_SETMUX) dir_q <= dec.dir;
      if (dec.kind == K_HALT) begin
        halt_q <= 1'b1;
      end else if (taken) begin
        bank_q <= {{(BANK_W-ARG_W){1'b0}}, dec.arg};
        pc_q   <= '0;
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  assign instr_bank = bank_q;
  assign instr_addr = pc_q;
  assign mux_dir    = dir_q;
  assign acc_val    = val_q;
  assign sign_flag  = sign_q;
  assign halted     = halt_q;
  assign halt_val   = halt_q ? val_q : '0;

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_ready && !opnd_valid) |=> ($stable(pc_q) && $stable(val_q) &&
                                     $stable(sign_q) && $stable(bank_q) && $stable(dir_q)));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && !stall && !taken && dec.kind != K_HALT) |=> (pc_q == $past(pc_q) + 1'b1));

  assert_jump_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && taken) |=> (pc_q == '0));

  assert_shift_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (dec.kind == K_SHL || dec.kind == K_SHR)) |=> $stable(sign_q));

  assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> (halt_q && $stable(val_q) && $stable(pc_q) && $stable(bank_q)));

  assert_halt_noready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> !opnd_ready);
endmodule

// File: tb/test_acc_core.sv
module test_acc_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] instr_bank;
  logic [7:0] instr_addr;
  logic [7:0] instr_data = 8'h00;
  logic       opnd_ready;
  logic       opnd_valid = 1'b0;
  logic [7:0] opnd_data = 8'h00;
  logic [4:0] mux_dir;
  logic [7:0] acc_val;
  logic       sign_flag;
  logic       halted;
  logic [7:0] halt_val;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  acc_core #(.PC_W(8), .BANK_W(8), .BOOT_BANK(6)) i_acc_core (
    .clk(clk), .rst_n(rst_n), .instr_bank(instr_bank), .instr_addr(instr_addr),
    .instr_data(instr_data), .opnd_ready(opnd_ready), .opnd_valid(opnd_valid),
    .opnd_data(opnd_data), .mux_dir(mux_dir), .acc_val(acc_val),
    .sign_flag(sign_flag), .halted(halted), .halt_val(halt_val)
  );

  localparam int N = 28;
  localparam logic [7:0] T_INS [0:N-1] = '{
    8'h15, 8'h2B, 8'h1F, 8'h41, 8'h32, 8'h6F, 8'h73, 8'h63, 8'h34, 8'h8A,
    8'h5F, 8'h02, 8'h02, 8'h03, 8'h04, 8'h05, 8'h00, 8'hA3, 8'hB3, 8'hC5,
    8'h11, 8'hC5, 8'h97, 8'hE5, 8'hF0, 8'h63, 8'hA4, 8'hB3};
  localparam logic T_OPV [0:N-1] = '{
    0,0,0,0,0,0,0,0,0,0, 0,0,1,1,1,1,0,0,0,0, 0,0,0,0,0,0,0,0};
  localparam logic [7:0] T_OPD [0:N-1] = '{
    8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
    8'h00, 8'h00, 8'h07, 8'hF0, 8'hF7, 8'h55, 8'h00, 8'h00, 8'h00, 8'h00,
    8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam logic [7:0] T_VAL [0:N-1] = '{
    8'h05, 8'hB5, 8'hBF, 8'h5F, 8'h7C, 8'h6D, 8'h01, 8'hFE, 8'hE0, 8'hEA,
    8'hF9, 8'hF9, 8'h07, 8'hF7, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
    8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'hFE, 8'hFE, 8'hFE};
  localparam logic T_SGN [0:N-1] = '{
    0,0,0,0,0,0,0,1,1,1, 1,1,1,1,0,0,0,0,0,0, 0,0,0,0,0,1,1,1};
  localparam logic [7:0] T_PC [0:N-1] = '{
    1,2,3,4,5,6,7,8,9,10, 11,11,12,13,14,15,16,17,0,1, 2,0,0,1,2,3,0,1};
  localparam logic [7:0] T_BANK [0:N-1] = '{
    6,6,6,6,6,6,6,6,6,6, 6,6,6,6,6,6,6,6,3,3, 3,5,7,7,7,7,4,4};
  localparam logic [4:0] T_MUX [0:N-1] = '{
    13,13,13,13,13,13,13,13,13,13, 13,13,13,13,13,13,13,13,13,13,
    13,13,13,5,16,16,16,16};
  localparam logic T_RDY [0:N-1] = '{
    0,0,0,0,0,0,0,0,0,0, 0,1,1,1,1,1,0,0,0,0, 0,0,0,0,0,0,0,0};

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] ins, input logic v, input logic [7:0] d);
    instr_data = ins;
    opnd_valid = v;
    opnd_data  = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "val", acc_val, 0);
    chk("R1", "sign", sign_flag, 0);
    chk("R1", "pc", instr_addr, 0);
    chk("R1", "bank", instr_bank, 6);
    chk("R1", "mux", mux_dir, 13);
    chk("R1", "halted", halted, 0);
    rst_n = 1'b1;

    // Vector table covering R2 to R9
    for (int i = 0; i < N; i++) begin
      instr_data = T_INS[i];
      opnd_valid = T_OPV[i];
      opnd_data  = T_OPD[i];
      #1;
      chk("R7", $sformatf("ready row %0d", i), opnd_ready, T_RDY[i]);
      @(posedge clk);
      @(negedge clk);
      chk("R3_R4_R5_R6_R7", $sformatf("val row %0d", i), acc_val, T_VAL[i]);
      chk("R4_R6", $sformatf("sign row %0d", i), sign_flag, T_SGN[i]);
      chk("R2_R8", $sformatf("pc row %0d", i), instr_addr, T_PC[i]);
      chk("R8", $sformatf("bank row %0d", i), instr_bank, T_BANK[i]);
      chk("R9", $sformatf("mux row %0d", i), mux_dir, T_MUX[i]);
    end

    // R2: PC wrap from 255 to 0
    step(8'h92, 1'b0, 8'h00);
    chk("R8", "jmp2 bank", instr_bank, 2);
    for (int k = 0; k < 255; k++) step(8'h00, 1'b0, 8'h00);
    chk("R2", "pc at 255", instr_addr, 255);
    step(8'hD7, 1'b0, 8'h00);
    chk("R2", "pc wrap", instr_addr, 0);
    chk("R2", "bank after wrap", instr_bank, 2);
    chk("R10", "reserved opcode nop val", acc_val, 8'hFE);

    // R10: halt freezes state
    chk("R10", "halt_val before halt", halt_val, 0);
    step(8'h01, 1'b0, 8'h00);
    chk("R10", "halted", halted, 1);
    chk("R10", "halt_val", halt_val, 8'hFE);
    held = instr_addr;
    step(8'h19, 1'b0, 8'h00);
    step(8'h97, 1'b0, 8'h00);
    chk("R10", "val frozen", acc_val, 8'hFE);
    chk("R10", "pc frozen", instr_addr, held);
    chk("R10", "bank frozen", instr_bank, 2);
    instr_data = 8'h02;
    #1;
    chk("R10", "ready low when halted", opnd_ready, 0);

    // R1: reset again after activity
    rst_n = 1'b0;
    step(8'h00, 1'b0, 8'h00);
    chk("R1", "re-reset val", acc_val, 0);
    chk("R1", "re-reset bank", instr_bank, 6);
    chk("R1", "re-reset halted", halted, 0);
    chk("R1", "re-reset halt_val", halt_val, 0);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule